// File: doc/BRIEF.md
# Pipelined Lowest-Set-Bit Index Encoder

This block takes a wide request vector every clock cycle and returns the position of its lowest-numbered set bit, together with a flag that says whether any bit was set. It is meant for wide search problems where one combinational encoder over the whole vector would limit the clock rate. One example is finding the first threshold crossing in a bank of comparators.

The vector is cut into equal groups. In the first pipeline stage, a small encoder on each group produces that group's local position and a flag that is set when any bit in the group is set. All of these results are registered. In the second stage, another small encoder takes the registered group flags and picks the winning group. Its number forms the upper bits of the result and selects the matching local position for the lower bits. The upper and lower bits are registered together, so the full result appears a fixed two cycles after the vector entered. A fresh vector can be applied every cycle.

The default build is a 64-bit vector in eight groups of eight, which uses nine 8-input encoders. The group width and total width are parameters and must be powers of two. The reset is active-low and asynchronous, and it is expected to be released in step with the clock.

Top module: `pe_tree`

## Requirements
- R1: When at least one input bit is set, `idx` equals the smallest bit position that was set in the vector applied two clocks earlier.
- R2: The latency is exactly two clock cycles, and a different vector may be applied on every consecutive cycle without loss or mixing between vectors.
- R3: When no input bit is set, `found` is 0 and `idx` is 0 two cycles later.
- R4: While `rst_n` is low, and until the first vector has passed through both stages, `found` is 0 and `idx` is 0.
- R5: When several bits inside one group are set, the lowest of them is reported.
- R6: When bits in several groups are set, a set bit in a lower-numbered group wins, whatever is set in higher-numbered groups.
- R7: `idx` is the group number (upper bits, width log2(WIDTH/GROUP_W)) concatenated with the position inside the group (lower bits, width log2(GROUP_W)). A single set bit at any position p, including the group edges and bit WIDTH-1, gives `idx` = p.
- R8: An all-ones vector gives `found` = 1 and `idx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vec | input | WIDTH | Request vector, sampled every cycle |
| idx | output | log2(WIDTH) | Position of the lowest set bit, valid two cycles later |
| found | output | 1 | 1 when the vector had at least one bit set |

## Verification
A stage-one register that is stuck or misaligned shows up at the ports as a wrong lower index, or as a wrong winning group. The error appears exactly two cycles after the vector that exposes it, because every result leaves the block at a fixed two-cycle offset. A select that uses the wrong cycle's local positions is caught by vectors that change on every cycle. In that case `idx` names a bit that was clear in the matching vector. The bench compares each result against the vector applied two cycles before it, so a single cycle of skew is reported on the first vector whose answer differs from its neighbour's.

// File: rtl/pe_pkg.sv
package pe_pkg;

  // Index width for a field that counts n positions (at least one bit).
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pe_leaf.sv
module pe_leaf
  import pe_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = idx_bits(W)
) (
  input  logic [W-1:0]  req,
  output logic [IW-1:0] pos,
  output logic          any
);

  // Scan from the top down so the lowest set bit writes last and wins.
  always_comb begin
    pos = '0;
    any = |req;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) pos = IW'(i);
    end
  end

endmodule

// File: rtl/pe_group_stage.sv
module pe_group_stage
  import pe_pkg::*;
#(
  parameter int unsigned GW = 8,
  parameter int unsigned NG = 8,
  parameter int unsigned LW = idx_bits(GW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GW*NG-1:0] vec,
  output logic [NG*LW-1:0] lo_q,
  output logic [NG-1:0]    any_q
);

  logic [NG*LW-1:0] lo_d;
  logic [NG-1:0]    any_d;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    pe_leaf #(.W(GW), .IW(LW)) u_leaf (
      .req (vec[g*GW +: GW]),
      .pos (lo_d[g*LW +: LW]),
      .any (any_d[g])
    );

    // R3: an empty group carries a zero local position forward
    p_empty_group_zero_r3: assert property (
      @(posedge clk) disable iff (!rst_n)
      !any_q[g] |-> (lo_q[g*LW +: LW] == '0)
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      any_q <= '0;
    end else begin
      lo_q  <= lo_d;
      any_q <= any_d;
    end
  end

endmodule

// File: rtl/pe_select_stage.sv
module pe_select_stage
  import pe_pkg::*;
#(
  parameter int unsigned NG = 8,
  parameter int unsigned LW = 3,
  parameter int unsigned HW = idx_bits(NG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NG*LW-1:0] lo_q,
  input  logic [NG-1:0]    any_q,
  output logic [HW+LW-1:0] idx_q,
  output logic             found_q
);

  logic [HW-1:0]    hi;
  logic             grp_any;
  logic [LW-1:0]    lo_sel;
  logic [HW+LW-1:0] idx_d;

  pe_leaf #(.W(NG), .IW(HW)) u_top_leaf (
    .req (any_q),
    .pos (hi),
    .any (grp_any)
  );

  always_comb begin
    lo_sel = lo_q[hi*LW +: LW];
    idx_d  = grp_any ? {hi, lo_sel} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      found_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      found_q <= grp_any;
    end
  end

  // Assertion support: group flags as seen by the cycle now at the output.
  logic [NG-1:0] any_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_prev <= '0;
    else        any_prev <= any_q;
  end

  // R6: the chosen group was flagged and no lower group was flagged
  p_lowest_group_r6: assert property (
    @(posedge clk) disable iff (!rst_n)
    found_q |-> (any_prev[idx_q[HW+LW-1:LW]] &&
                 ((any_prev & ((NG'(1) << idx_q[HW+LW-1:LW]) - NG'(1))) == '0))
  );

  // R3: the found flag follows the presence of any flagged group
  p_found_from_groups_r3: assert property (
    @(posedge clk) disable iff (!rst_n)
    found_q == (|any_prev)
  );

endmodule

// File: rtl/pe_tree.sv
module pe_tree
  import pe_pkg::*;
#(
  parameter int unsigned WIDTH   = 64,
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned NG = WIDTH / GROUP_W,
  localparam int unsigned LW = idx_bits(GROUP_W),
  localparam int unsigned HW = idx_bits(NG),
  localparam int unsigned IW = LW + HW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req_vec,
  output logic [IW-1:0]    idx,
  output logic             found
);

  logic [NG*LW-1:0] s1_lo;
  logic [NG-1:0]    s1_any;

  initial begin
    a_shape_ok: assert ((NG * GROUP_W == WIDTH) && ((1 << IW) == WIDTH))
      else $error("pe_tree: WIDTH and GROUP_W must be powers of two");
  end

  pe_group_stage #(.GW(GROUP_W), .NG(NG), .LW(LW)) u_stage1 (
    .clk   (clk),
    .rst_n (rst_n),
    .vec   (req_vec),
    .lo_q  (s1_lo),
    .any_q (s1_any)
  );

  pe_select_stage #(.NG(NG), .LW(LW), .HW(HW)) u_stage2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_q    (s1_lo),
    .any_q   (s1_any),
    .idx_q   (idx),
    .found_q (found)
  );

  // Assertion support: the input vector delayed by the pipeline depth.
  logic [WIDTH-1:0] vec_d1, vec_d2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_d1 <= '0;
      vec_d2 <= '0;
    end else begin
      vec_d1 <= req_vec;
      vec_d2 <= vec_d1;
    end
  end

  // R1: reported bit was set and nothing below it was
  p_lowest_bit_r1: assert property (
    @(posedge clk) disable iff (!rst_n)
    found |-> (vec_d2[idx] && ((vec_d2 & ((WIDTH'(1) << idx) - WIDTH'(1))) == '0))
  );

  // R2: found reflects the vector from exactly two cycles before
  p_latency_r2: assert property (
    @(posedge clk) disable iff (!rst_n)
    found == (|vec_d2)
  );

  // R3: an empty result carries a zero index
  p_zero_idx_r3: assert property (
    @(posedge clk) disable iff (!rst_n)
    !found |-> (idx == '0)
  );

endmodule

// File: tb/sim_pe_tree.sv
module sim_pe_tree;

  localparam int W  = 64;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  req_vec;
  logic [IW-1:0] idx;
  logic          found;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [W-1:0] pipe_v [2];
  string        pipe_t [2];

  always #2 clk = ~clk;

  pe_tree #(.WIDTH(W), .GROUP_W(8)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_vec (req_vec),
    .idx     (idx),
    .found   (found)
  );

  function automatic logic [IW-1:0] exp_idx(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) if (v[i]) return IW'(i);
    return '0;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] v);
    logic [IW-1:0] ei;
    logic          ef;
    ei = exp_idx(v);
    ef = |v;
    checks++;
    if (idx !== ei || found !== ef) begin
      errors++;
      $display("FAIL %s vec=%h idx=%0d found=%0b expected idx=%0d found=%0b",
               tag, v, idx, found, ei, ef);
    end
  endtask

  // At a falling edge: check the result of the vector driven two steps ago,
  // then drive the next vector.
  task automatic step(input logic [W-1:0] v, input string tag);
    @(negedge clk);
    check(pipe_t[1], pipe_v[1]);
    pipe_v[1] = pipe_v[0];
    pipe_t[1] = pipe_t[0];
    pipe_v[0] = v;
    pipe_t[0] = tag;
    req_vec   = v;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd20240611));
    rst_n   = 1'b0;
    req_vec = '1;
    pipe_v[0] = '0; pipe_v[1] = '0;
    pipe_t[0] = "R4"; pipe_t[1] = "R4";
    repeat (3) @(negedge clk);
    check("R4", '0);
    @(negedge clk);
    rst_n   = 1'b1;
    req_vec = '0;

    step('0, "R3");
    step('1, "R8");
    step('0, "R3");
    // R7: every single-bit position, back to back (also R2)
    for (int p = 0; p < W; p++) step(W'(1) << p, "R7");
    // R5: ties inside one group
    step((W'(1) << 13) | (W'(1) << 11) | (W'(1) << 15), "R5");
    step(64'h0000_0000_00F0_0000, "R5");
    // R6: lower group beats higher groups
    step((W'(1) << 60) | (W'(1) << 9), "R6");
    step(64'hFFFF_FFFF_FFFF_FF00 | (W'(1) << 7), "R6");
    step(64'h8000_0000_0000_0000, "R7");
    // R2: alternating empty and full on consecutive cycles
    for (int k = 0; k < 8; k++) step((k % 2) ? '1 : '0, "R2");
    // R1: random vectors of varied density
    for (int n = 0; n < 3000; n++) begin
      v = {$urandom, $urandom};
      case ($urandom % 4)
        0: v = W'(1) << ($urandom % W);
        1: v = v & {$urandom, $urandom} & {$urandom, $urandom};
        2: if (($urandom % 8) == 0) v = '0;
        default: ;
      endcase
      step(v, "R1");
    end
    step('0, "R3");
    step('0, "R3");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule